// File: doc/BRIEF.md
# Quota-Window Memory Request Throttle

This block sits in the request path between a memory request source and the scheduler of a memory controller. It caps memory traffic with a hard transaction quota: time is cut into back-to-back windows of M clock cycles, and within each window only the first N handshakes are let through. Requests are admitted the moment they arrive while quota remains, wherever they fall in the window. Once the quota is spent, the block withholds `up_ready` and `dn_valid`. The source holds its request until the first cycle of the following window.

Reads and writes draw on the same quota. Setting N at or above M, or raising the bypass input, gives unthrottled operation. In that mode the block is a plain wire for the handshake. The quota, period and bypass inputs are sampled only at a window boundary. A new setting therefore never applies to part of a window. Two saturating counters report how many transactions issued and how many cycles a waiting request was held back by the quota.

The request path is combinational: payload and valid pass straight through, and the block only masks the handshake. No request storage is added.

Top module: `qwt_throttle`

## Requirements
- R1: In throttled mode no more than N handshakes (`up_valid` and `up_ready` both high) complete in any window.
- R2: While fewer than N handshakes have completed in the current window, `up_ready` equals `dn_ready` in every cycle, at any position in the window.
- R3: Once N handshakes have completed in a window, `up_ready` and `dn_valid` stay low for the rest of that window and are released on the first cycle of the next window.
- R4: A read (`up_write`=0) and a write (`up_write`=1) each use one unit of the same quota.
- R5: When the active bypass bit is 1 or the active N is greater than or equal to the active M, `up_ready` equals `dn_ready` and `dn_valid` equals `up_valid` in every cycle.
- R6: A window lasts exactly M cycles. The first window starts in the first cycle after reset is released. An M of 0 behaves as a window of one cycle.
- R7: Quota, period and bypass inputs are sampled during reset and in the last cycle of each window. They govern the whole of the next window, and changes at other times have no effect on the current window.
- R8: `stat_issued` counts completed handshakes and saturates at its all-ones value.
- R9: `stat_stalled` counts cycles in which `up_valid` is high and the quota blocks the request. It saturates at its all-ones value. Cycles blocked only by `dn_ready` are not counted.
- R10: `dn_valid` is high only when `up_valid` is high. `dn_write`, `dn_addr` and `dn_tag` always equal their upstream counterparts.
- R11: After a synchronous reset both counters are zero and a new window begins with its full quota.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_quota | input | 8 | Transactions allowed per window (N) |
| cfg_period | input | 8 | Window length in cycles (M) |
| cfg_bypass | input | 1 | Forces unthrottled operation |
| up_valid | input | 1 | Request present from source |
| up_ready | output | 1 | Request accepted this cycle |
| up_write | input | 1 | 1 = write, 0 = read |
| up_addr | input | 32 | Request address |
| up_tag | input | 6 | Request tag |
| dn_valid | output | 1 | Request offered to scheduler |
| dn_ready | input | 1 | Scheduler can accept |
| dn_write | output | 1 | Forwarded write flag |
| dn_addr | output | 32 | Forwarded address |
| dn_tag | output | 6 | Forwarded tag |
| stat_issued | output | STAT_W | Saturating issued-transaction count |
| stat_stalled | output | STAT_W | Saturating quota-stall cycle count |

## Verification
The handshake outputs `up_ready`, `dn_valid` and the payload follow the inputs in the same cycle. The quota state behind them changes only at a rising edge. The bench drives at the falling edge, waits a short delay and compares in that same cycle, then lets one rising edge pass to update its own window position and grant count. Counter values are due one edge after the handshake or stall that causes them. They are compared after the final edge of each run, and the reset-state check follows the last reset edge.

// File: rtl/qwt_pkg.sv
package qwt_pkg;
    localparam int CYC_W  = 8;
    localparam int ADDR_W = 32;
    localparam int TAG_W  = 6;

    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [TAG_W-1:0]  tag;
    } qwt_req_t;

    typedef struct packed {
        logic             bypass;
        logic [CYC_W-1:0] quota;
        logic [CYC_W-1:0] period;
    } qwt_cfg_t;

    function automatic logic is_open(qwt_cfg_t c);
        return c.bypass || (c.quota >= c.period);
    endfunction
endpackage

// File: rtl/qwt_window.sv
module qwt_window
    import qwt_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  qwt_cfg_t cfg_in,
    output qwt_cfg_t act,
    output logic     last
);
    logic [CYC_W-1:0] cyc;

    always_comb begin
        if (act.period == '0) last = 1'b1;
        else                  last = (cyc == act.period - 1'b1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cyc <= '0;
            act <= cfg_in;
        end else if (last) begin
            cyc <= '0;
            act <= cfg_in;
        end else begin
            cyc <= cyc + 1'b1;
        end
    end
endmodule

// File: rtl/qwt_gate.sv
module qwt_gate
    import qwt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  qwt_cfg_t         act,
    input  logic             last,
    input  logic             up_valid,
    input  logic             dn_ready,
    output logic             allow,
    output logic             unthr,
    output logic             fire,
    output logic             stall,
    output logic [CYC_W-1:0] used
);
    always_comb begin
        unthr = is_open(act);
        allow = unthr || (used < act.quota);
        fire  = up_valid && dn_ready && allow;
        stall = up_valid && !allow;
    end

    always_ff @(posedge clk) begin
        if (rst || last)          used <= '0;
        else if (fire && !unthr)  used <= used + 1'b1;
    end
endmodule

// File: rtl/qwt_stats.sv
module qwt_stats #(
    parameter int STAT_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fire,
    input  logic              stall,
    output logic [STAT_W-1:0] issued,
    output logic [STAT_W-1:0] stalled
);
    localparam logic [STAT_W-1:0] TOP = {STAT_W{1'b1}};

    always_ff @(posedge clk) begin
        if (rst) begin
            issued  <= '0;
            stalled <= '0;
        end else begin
            if (fire && issued != TOP)   issued  <= issued + 1'b1;
            if (stall && stalled != TOP) stalled <= stalled + 1'b1;
        end
    end
endmodule

// File: rtl/qwt_throttle.sv
module qwt_throttle
    import qwt_pkg::*;
#(
    parameter int STAT_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CYC_W-1:0]  cfg_quota,
    input  logic [CYC_W-1:0]  cfg_period,
    input  logic              cfg_bypass,
    input  logic              up_valid,
    output logic              up_ready,
    input  logic              up_write,
    input  logic [ADDR_W-1:0] up_addr,
    input  logic [TAG_W-1:0]  up_tag,
    output logic              dn_valid,
    input  logic              dn_ready,
    output logic              dn_write,
    output logic [ADDR_W-1:0] dn_addr,
    output logic [TAG_W-1:0]  dn_tag,
    output logic [STAT_W-1:0] stat_issued,
    output logic [STAT_W-1:0] stat_stalled
);
    qwt_cfg_t         cfg_in, act_cfg;
    qwt_req_t         req;
    logic             win_last, gate_allow, gate_unthr, gate_fire, gate_stall;
    logic [CYC_W-1:0] gate_used;

    assign cfg_in = '{bypass: cfg_bypass, quota: cfg_quota, period: cfg_period};
    assign req    = '{wr: up_write, addr: up_addr, tag: up_tag};

    qwt_window u_window (
        .clk(clk), .rst(rst), .cfg_in(cfg_in), .act(act_cfg), .last(win_last)
    );

    qwt_gate u_gate (
        .clk(clk), .rst(rst), .act(act_cfg), .last(win_last),
        .up_valid(up_valid), .dn_ready(dn_ready), .allow(gate_allow),
        .unthr(gate_unthr), .fire(gate_fire), .stall(gate_stall), .used(gate_used)
    );

    qwt_stats #(.STAT_W(STAT_W)) u_stats (
        .clk(clk), .rst(rst), .fire(gate_fire), .stall(gate_stall),
        .issued(stat_issued), .stalled(stat_stalled)
    );

    assign up_ready = dn_ready && gate_allow;
    assign dn_valid = up_valid && gate_allow;
    assign dn_write = req.wr;
    assign dn_addr  = req.addr;
    assign dn_tag   = req.tag;
endmodule

// File: rtl/qwt_checks.sv
module qwt_checks
    import qwt_pkg::*;
#(
    parameter int STAT_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              up_valid,
    input logic              up_ready,
    input logic              dn_valid,
    input logic              dn_ready,
    input logic [ADDR_W-1:0] up_addr,
    input logic [ADDR_W-1:0] dn_addr,
    input logic              last,
    input logic              unthr,
    input logic [CYC_W-1:0]  used,
    input logic [CYC_W-1:0]  act_quota,
    input logic [STAT_W-1:0] stat_issued,
    input logic [STAT_W-1:0] stat_stalled
);
    AST_QUOTA_BOUND: assert property (@(posedge clk) disable iff (rst)
        !unthr |-> used <= act_quota); // R1
    AST_HOLD_TO_EDGE: assert property (@(posedge clk) disable iff (rst)
        (!unthr && !last && used >= act_quota) |=> (!up_ready && !dn_valid)); // R3
    AST_OPEN_WIRE: assert property (@(posedge clk) disable iff (rst)
        unthr |-> (up_ready == dn_ready && dn_valid == up_valid)); // R5
    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (rst)
        !last |=> $stable(act_quota)); // R7
    AST_ISSUED_MONO: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> stat_issued >= $past(stat_issued)); // R8
    AST_STALL_MONO: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> stat_stalled >= $past(stat_stalled)); // R9
    AST_VALID_SOURCE: assert property (@(posedge clk) disable iff (rst)
        dn_valid |-> (up_valid && dn_addr == up_addr)); // R10
endmodule

bind qwt_throttle qwt_checks #(.STAT_W(STAT_W)) u_checks (
    .clk(clk), .rst(rst), .up_valid(up_valid), .up_ready(up_ready),
    .dn_valid(dn_valid), .dn_ready(dn_ready), .up_addr(up_addr), .dn_addr(dn_addr),
    .last(win_last), .unthr(gate_unthr), .used(gate_used),
    .act_quota(act_cfg.quota), .stat_issued(stat_issued), .stat_stalled(stat_stalled)
);

// File: tb/qwt_throttle_bench.sv
module qwt_throttle_bench;
    import qwt_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [CYC_W-1:0] cfg_quota = '0, cfg_period = '0;
    logic cfg_bypass = 1'b0;
    logic up_valid = 1'b0, up_write = 1'b0, dn_ready = 1'b0;
    logic [ADDR_W-1:0] up_addr = '0;
    logic [TAG_W-1:0] up_tag = '0;
    logic up_ready, dn_valid, dn_write;
    logic [ADDR_W-1:0] dn_addr;
    logic [TAG_W-1:0] dn_tag;
    logic [31:0] stat_issued, stat_stalled;
    logic s_ur, s_dv, s_dw;
    logic [ADDR_W-1:0] s_da;
    logic [TAG_W-1:0] s_dt;
    logic [3:0] s_iss, s_stl;

    int vectors = 0, errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    qwt_throttle u_qwt_throttle (
        .clk(clk), .rst(rst), .cfg_quota(cfg_quota), .cfg_period(cfg_period),
        .cfg_bypass(cfg_bypass), .up_valid(up_valid), .up_ready(up_ready),
        .up_write(up_write), .up_addr(up_addr), .up_tag(up_tag),
        .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_write(dn_write),
        .dn_addr(dn_addr), .dn_tag(dn_tag),
        .stat_issued(stat_issued), .stat_stalled(stat_stalled)
    );

    qwt_throttle #(.STAT_W(4)) u_qwt_throttle_sat (
        .clk(clk), .rst(rst), .cfg_quota(cfg_quota), .cfg_period(cfg_period),
        .cfg_bypass(cfg_bypass), .up_valid(up_valid), .up_ready(s_ur),
        .up_write(up_write), .up_addr(up_addr), .up_tag(up_tag),
        .dn_valid(s_dv), .dn_ready(dn_ready), .dn_write(s_dw),
        .dn_addr(s_da), .dn_tag(s_dt), .stat_issued(s_iss), .stat_stalled(s_stl)
    );

    task automatic chk(string req, string what, longint act, longint exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic longint sat15(longint v);
        return (v > 15) ? 15 : v;
    endfunction

    task automatic run_cfg(int n, int m, int b, int pat, int chg);
        int pos = 0, granted = 0, iss = 0, stl = 0;
        int mn = n, mm = m, mb = b;
        cfg_quota = n[CYC_W-1:0]; cfg_period = m[CYC_W-1:0]; cfg_bypass = b[0];
        rst = 1'b1;
        @(posedge clk); @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1;
        // R11 reset state
        chk("R11", "issued after reset", stat_issued, 0);
        chk("R11", "stalled after reset", stat_stalled, 0);
        for (int t = 0; t < 36; t++) begin
            bit v, r, op, allow, fire, lst;
            v = (pat == 1) ? (t % 2 == 0) : 1'b1;
            r = (pat == 2) ? (t % 3 != 1) : 1'b1;
            if (chg != 0 && t == 3) begin
                cfg_quota = CYC_W'((n + 2) % 5); cfg_period = CYC_W'((m % 5) + 2);
                cfg_bypass = 1'b0;
            end
            up_valid = v; dn_ready = r; up_write = t[0];
            up_addr = 32'h1000_0000 + 32'(t * 64 + n); up_tag = TAG_W'(t + m);
            #1;
            op = (mb != 0) || (mn >= mm);
            allow = op || (granted < mn);
            if (op) begin
                chk("R5", "up_ready open", up_ready, r);
                chk("R5", "dn_valid open", dn_valid, v);
            end else if (allow) begin
                // R2 R4 quota remaining, reads and writes alike
                chk("R2", "up_ready in quota", up_ready, r);
                chk("R10", "dn_valid in quota", dn_valid, v);
            end else begin
                chk("R3", "up_ready blocked", up_ready, 0);
                chk("R3", "dn_valid blocked", dn_valid, 0);
            end
            chk("R10", "dn_addr", dn_addr, up_addr);
            chk("R10", "dn_tag", dn_tag, up_tag);
            chk("R4", "dn_write", dn_write, up_write);
            fire = v && r && allow;
            if (fire) iss++;
            if (v && !allow) stl++;
            lst = (mm == 0) || (pos == mm - 1);
            if (lst) begin
                // R6 R7 window edge reloads settings
                pos = 0; granted = 0;
                mn = int'(cfg_quota); mm = int'(cfg_period); mb = int'(cfg_bypass);
            end else begin
                pos++;
                if (fire && !op) granted++;
            end
            @(negedge clk);
        end
        #1;
        chk("R8", "stat_issued", stat_issued, iss);
        chk("R9", "stat_stalled", stat_stalled, stl);
        chk("R8", "issued saturating", s_iss, sat15(iss));
        chk("R9", "stalled saturating", s_stl, sat15(stl));
        // R1 handshakes bounded by quota over the run
        if (b == 0 && n < m && m != 0 && chg == 0)
            chk("R1", "issued within quota", iss <= n * ((36 + m - 1) / m), 1);
    endtask

    initial begin
        for (int b = 0; b < 2; b++)
            for (int n = 0; n < 6; n++)
                for (int m = 0; m < 7; m++)
                    for (int p = 0; p < 3; p++)
                        run_cfg(n, m, b, p, 0);
        for (int n = 0; n < 4; n++)
            for (int m = 2; m < 7; m++)
                run_cfg(n, m, 0, 0, 1);   // R7 mid-window change
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end
endmodule